// File: doc/BRIEF.md
# Counter clock and gate routing

This block sits in front of a bank of three-channel counter chips and decides, for every counter channel, where its count clock and its gate come from. Each channel has a 3-bit clock-source code and a 3-bit gate-source code. Both codes are held in one select register per channel, which is written and read over a small synchronous register port. The counters themselves live elsewhere. This block hands each channel a single-cycle clock-enable and a gate level, and it takes back each channel's OUT signal.

The clock sources for a channel are:
- the channel's own external clock pin,
- the chip's shared external clock pin,
- the OUT of the preceding channel,
- five internal rates, produced as enable pulses from the 10 MHz reference clock through a chain of divide-by-ten stages.

The gate sources for a channel are:
- a constant high,
- a constant low,
- the channel's own external gate pin,
- the inverted OUT of a channel two positions back.

The chips are linked in a ring, so the first channels of a chip reach back into the highest-numbered neighbouring chip when chip 0 is involved. Each channel's external clock and gate pins are inputs only while they are selected as the source. Otherwise the block drives them with the routed clock-enable or gate.

Level sources (pins and OUT signals) are taken to be synchronous to the reference clock. A clock-enable is produced in the cycle where such a source is first seen high after being low.

Top module: `ctr_route_top`

## Requirements
- R1: After a synchronous active-low reset, every select register reads 0x10 (clock code 0, gate code 2). All pin output enables are 0. With all inputs low, every clock-enable and gate output is 0.
- R2: Writing the select registers:
  - A write with `cfg_we` high stores `cfg_wdata` in the channel at `cfg_addr`. Bits [2:0] hold the clock code and bits [5:3] hold the gate code.
  - `cfg_rdata` returns the last value written to `cfg_addr` from the next cycle on.
  - A write to an address of 3·NUM_CHIPS or above changes no register, and a read there returns 0.
- R3: Clock codes 1, 2, 3, 4 and 5 give a clock-enable pulse every 1, 10, 100, 1000 and 10000 reference cycles respectively (10 MHz down to 1 kHz from a 10 MHz reference).
- R4: Clock code 0 gives a clock-enable in exactly the cycle where the channel's own clock pin is first seen high after being low. No other pin affects it.
- R5: Clock code 6 gives a clock-enable on a rising edge of OUT of the preceding channel:
  - channels 1 and 2 of a chip use channel n-1 of the same chip;
  - channel 0 uses channel 2 of the preceding chip, and chip 0 is preceded by the highest chip.
- R6: The gate output for each gate code is:
  - code 0: high;
  - code 1: low;
  - code 2: follows the channel's own gate pin;
  - codes 4 to 7: low.
- R7: Gate code 3 gives the inverted OUT of a channel two positions back:
  - channel 2 uses channel 0 of the same chip;
  - channels 0 and 1 use channel n+1 of the preceding chip, in the same ring order as R5.
- R8: Pin direction and pin drive:
  - A channel's clock pin output enable is 1 exactly when its clock code is not 0. While enabled, the pin carries the channel's clock-enable.
  - The gate pin output enable is 1 exactly when the gate code is not 2. While enabled, the pin carries the channel's gate.
  - A pin that is not enabled is driven with 0.
- R9: Clock code 7 gives a clock-enable on a rising edge of the chip's shared clock pin. That one pin serves all three channels of its chip, and the shared pins of other chips have no effect.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst_n | input | 1 | synchronous active-low reset |
| cfg_we | input | 1 | select register write strobe |
| cfg_addr | input | AW = clog2(3·NUM_CHIPS) | channel index for write and read |
| cfg_wdata | input | 6 | {gate code, clock code} to write |
| cfg_rdata | output | 6 | select register at `cfg_addr` |
| ch_clk_pin_i | input | 3·NUM_CHIPS | per-channel external clock pin, input value |
| ch_gat_pin_i | input | 3·NUM_CHIPS | per-channel external gate pin, input value |
| chip_xclk_i | input | NUM_CHIPS | per-chip shared external clock pin |
| ch_out_i | input | 3·NUM_CHIPS | OUT of each counter channel |
| ch_clk_en_o | output | 3·NUM_CHIPS | clock-enable pulse to each counter channel |
| ch_gate_o | output | 3·NUM_CHIPS | gate level to each counter channel |
| ch_clk_pin_oe | output | 3·NUM_CHIPS | clock pin drive enable |
| ch_clk_pin_o | output | 3·NUM_CHIPS | clock pin drive value |
| ch_gat_pin_oe | output | 3·NUM_CHIPS | gate pin drive enable |
| ch_gat_pin_o | output | 3·NUM_CHIPS | gate pin drive value |

## Verification
The bench is set up with three chips and walks every channel through the clock codes that follow a level source.

For each such code it first raises every candidate source except the selected one, then raises the selected one. A wrong ring index or a wrong pin therefore shows up either as a spurious enable or as a missing one. Repeating the check one cycle later, with the source still high, separates edge detection from level following.

Every gate code is tried on every channel with four input patterns: all low, all high, only the source low, and only the source high. These patterns tell a constant output apart from a followed signal, and the correct inverted neighbour apart from any other channel.

The internal rates are checked by measuring the exact interval between successive pulses. The register port is checked for exact read-back, for writes to unused addresses being ignored, and for the reset values.

// File: rtl/ctr_route_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the counter clock and gate router.
// Assumes three counter channels per chip and 3-bit select codes.
package ctr_route_pkg;
    localparam int CH_PER_CHIP = 3;
    localparam int CODE_W      = 3;
    localparam int SEL_W       = 2 * CODE_W;
    localparam int NUM_RATES   = 5;

    // clock source codes with behaviour beyond the internal rates
    localparam logic [CODE_W-1:0] CK_PIN    = 3'd0;
    localparam logic [CODE_W-1:0] CK_CHAIN  = 3'd6;
    localparam logic [CODE_W-1:0] CK_SHARED = 3'd7;

    // gate source codes; codes 4..7 are reserved and give a low gate
    localparam logic [CODE_W-1:0] GT_HIGH  = 3'd0;
    localparam logic [CODE_W-1:0] GT_LOW   = 3'd1;
    localparam logic [CODE_W-1:0] GT_PIN   = 3'd2;
    localparam logic [CODE_W-1:0] GT_CHAIN = 3'd3;

    // per-channel select register, gate code in the upper field
    typedef struct packed {
        logic [CODE_W-1:0] gate;
        logic [CODE_W-1:0] clk;
    } chan_sel_t;

    localparam chan_sel_t SEL_RESET = '{gate: GT_PIN, clk: CK_PIN};
endpackage

// File: rtl/ctr_rate_gen.sv
`timescale 1ns/1ps
// Internal rate generator: a chain of divide-by-RATIO stages that turns the
// reference clock into single-cycle enable pulses. tick[0] is every cycle,
// tick[k] one cycle in RATIO**k. No derived clocks are created.
// Assumes RATIO >= 2.
module ctr_rate_gen #(
    parameter int RATIO  = 10,
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES:0]   tick
);
    localparam int           CW   = $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    assign tick[0] = 1'b1;

    for (genvar k = 1; k <= STAGES; k++) begin : g_stage
        logic [CW-1:0] cnt;

        // advance this decade once per pulse of the faster stage
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= '0;
            else if (tick[k-1])
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end

        assign tick[k] = tick[k-1] && (cnt == LAST);

        // R3: a stage pulse always restarts its decade
        a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            tick[k] |=> (cnt == '0));
        // R3: decade counter never leaves its range
        a_r3_range: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= LAST);
    end
endmodule

// File: rtl/ctr_sel_regs.sv
`timescale 1ns/1ps
// Select register file: one {gate, clock} code pair per channel.
// Writes to addresses at or beyond NCH are dropped; reads there give 0.
module ctr_sel_regs
    import ctr_route_pkg::*;
#(
    parameter int NCH = 6,
    parameter int AW  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic [SEL_W-1:0]           wdata,
    output logic [SEL_W-1:0]           rdata,
    output chan_sel_t [NCH-1:0]        sel
);
    // store a write into the addressed channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) sel[i] <= SEL_RESET;
        end else if (we) begin
            for (int i = 0; i < NCH; i++)
                if (addr == AW'(i)) sel[i] <= chan_sel_t'(wdata);
        end
    end

    // read back the addressed channel, zero when unmapped
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (addr == AW'(i)) rdata = sel[i];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R2: an addressed write lands in the register
        a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
            (we && addr == AW'(i)) |=> (sel[i] == $past(wdata)));
        // R2: other writes leave the register alone
        a_r2_keep: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && addr == AW'(i)) |=> $stable(sel[i]));
    end
endmodule

// File: rtl/ctr_chan_route.sv
`timescale 1ns/1ps
// Per-channel source selection. Purely combinational: picks the clock
// enable and gate from prepared candidates and sets the pin directions.
// Assumes edge detection of level sources is done by the caller.
module ctr_chan_route
    import ctr_route_pkg::*;
#(
    parameter int NRATE = 5
) (
    input  chan_sel_t           sel,
    input  logic [NRATE-1:0]    rate_tick,
    input  logic                pin_clk_rise,
    input  logic                shared_clk_rise,
    input  logic                chain_clk_rise,
    input  logic                pin_gat_lvl,
    input  logic                chain_out_lvl,
    output logic                clk_en,
    output logic                gate,
    output logic                clk_pin_oe,
    output logic                clk_pin_o,
    output logic                gat_pin_oe,
    output logic                gat_pin_o
);
    // choose the clock-enable source
    always_comb begin
        case (sel.clk)
            CK_PIN:    clk_en = pin_clk_rise;
            CK_CHAIN:  clk_en = chain_clk_rise;
            CK_SHARED: clk_en = shared_clk_rise;
            default:   clk_en = rate_tick[sel.clk - 3'd1];
        endcase
    end

    // choose the gate level, reserved codes hold the gate low
    always_comb begin
        case (sel.gate)
            GT_HIGH:  gate = 1'b1;
            GT_LOW:   gate = 1'b0;
            GT_PIN:   gate = pin_gat_lvl;
            GT_CHAIN: gate = !chain_out_lvl;
            default:  gate = 1'b0;
        endcase
    end

    // pins receive only while selected, otherwise carry the routed signal
    always_comb begin
        clk_pin_oe = (sel.clk != CK_PIN);
        clk_pin_o  = clk_pin_oe && clk_en;
        gat_pin_oe = (sel.gate != GT_PIN);
        gat_pin_o  = gat_pin_oe && gate;
    end
endmodule

// File: rtl/ctr_route_top.sv
`timescale 1ns/1ps
// Counter clock and gate router for NUM_CHIPS three-channel counter chips.
// Channel g = chip*3 + n. Chips form a ring: chip 0 follows the last chip.
// Assumes all pin and OUT inputs are synchronous to the 10 MHz clk.
module ctr_route_top
    import ctr_route_pkg::*;
#(
    parameter int NUM_CHIPS = 2,
    parameter int RATIO     = 10,
    localparam int NCH      = NUM_CHIPS * CH_PER_CHIP,
    localparam int AW       = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [SEL_W-1:0]     cfg_wdata,
    output logic [SEL_W-1:0]     cfg_rdata,
    input  logic [NCH-1:0]       ch_clk_pin_i,
    input  logic [NCH-1:0]       ch_gat_pin_i,
    input  logic [NUM_CHIPS-1:0] chip_xclk_i,
    input  logic [NCH-1:0]       ch_out_i,
    output logic [NCH-1:0]       ch_clk_en_o,
    output logic [NCH-1:0]       ch_gate_o,
    output logic [NCH-1:0]       ch_clk_pin_oe,
    output logic [NCH-1:0]       ch_clk_pin_o,
    output logic [NCH-1:0]       ch_gat_pin_oe,
    output logic [NCH-1:0]       ch_gat_pin_o
);
    chan_sel_t [NCH-1:0]   sel_q;
    logic [NUM_RATES-1:0]  tick;
    logic [NCH-1:0]        pin_q, out_q;
    logic [NUM_CHIPS-1:0]  xclk_q;
    logic [NCH-1:0]        pin_rise, out_rise;
    logic [NUM_CHIPS-1:0]  xclk_rise;

    ctr_sel_regs #(.NCH(NCH), .AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .sel   (sel_q)
    );

    ctr_rate_gen #(.RATIO(RATIO), .STAGES(NUM_RATES - 1)) u_rates (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // remember last-cycle levels of every level source for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= '0;
            out_q  <= '0;
            xclk_q <= '0;
        end else begin
            pin_q  <= ch_clk_pin_i;
            out_q  <= ch_out_i;
            xclk_q <= chip_xclk_i;
        end
    end

    assign pin_rise  = ch_clk_pin_i & ~pin_q;
    assign out_rise  = ch_out_i     & ~out_q;
    assign xclk_rise = chip_xclk_i  & ~xclk_q;

    for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
        localparam int PREV = (c == 0) ? NUM_CHIPS - 1 : c - 1;
        for (genvar n = 0; n < CH_PER_CHIP; n++) begin : g_ch
            localparam int G      = c * CH_PER_CHIP + n;
            localparam int CK_SRC = (n > 0) ? G - 1 : PREV * CH_PER_CHIP + 2;
            localparam int GT_SRC = (n == 2) ? c * CH_PER_CHIP
                                             : PREV * CH_PER_CHIP + n + 1;

            ctr_chan_route #(.NRATE(NUM_RATES)) u_route (
                .sel             (sel_q[G]),
                .rate_tick       (tick),
                .pin_clk_rise    (pin_rise[G]),
                .shared_clk_rise (xclk_rise[c]),
                .chain_clk_rise  (out_rise[CK_SRC]),
                .pin_gat_lvl     (ch_gat_pin_i[G]),
                .chain_out_lvl   (ch_out_i[GT_SRC]),
                .clk_en          (ch_clk_en_o[G]),
                .gate            (ch_gate_o[G]),
                .clk_pin_oe      (ch_clk_pin_oe[G]),
                .clk_pin_o       (ch_clk_pin_o[G]),
                .gat_pin_oe      (ch_gat_pin_oe[G]),
                .gat_pin_o       (ch_gat_pin_o[G])
            );

            // R8: an undriven clock pin carries nothing
            a_r8_clk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                !ch_clk_pin_oe[G] |-> !ch_clk_pin_o[G]);
            // R8: an undriven gate pin carries nothing
            a_r8_gat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                !ch_gat_pin_oe[G] |-> !ch_gat_pin_o[G]);
            // R6: gate code 0 holds the gate open
            a_r6_gate_high: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_q[G].gate == GT_HIGH) |-> ch_gate_o[G]);
            // R6: reserved gate codes keep the gate closed
            a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
                sel_q[G].gate[2] |-> !ch_gate_o[G]);
            // R4: a selected own pin held high gives no second enable
            a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_q[G].clk == CK_PIN && ch_clk_pin_i[G]) |=>
                (sel_q[G].clk != CK_PIN || !ch_clk_pin_i[G] || !ch_clk_en_o[G]));
        end
    end
endmodule

// File: tb/ctr_route_top_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: three chips, sweeps all channels and codes.
module ctr_route_top_tb_top;
    localparam int NC  = 3;
    localparam int NCH = NC * 3;
    localparam int AW  = $clog2(NCH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [5:0] cfg_wdata = '0;
    logic [5:0] cfg_rdata;
    logic [NCH-1:0] ch_clk_pin_i = '0, ch_gat_pin_i = '0, ch_out_i = '0;
    logic [NC-1:0]  chip_xclk_i = '0;
    logic [NCH-1:0] ch_clk_en_o, ch_gate_o, ch_clk_pin_oe, ch_clk_pin_o;
    logic [NCH-1:0] ch_gat_pin_oe, ch_gat_pin_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ctr_route_top #(.NUM_CHIPS(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ch_clk_pin_i(ch_clk_pin_i), .ch_gat_pin_i(ch_gat_pin_i),
        .chip_xclk_i(chip_xclk_i), .ch_out_i(ch_out_i),
        .ch_clk_en_o(ch_clk_en_o), .ch_gate_o(ch_gate_o),
        .ch_clk_pin_oe(ch_clk_pin_oe), .ch_clk_pin_o(ch_clk_pin_o),
        .ch_gat_pin_oe(ch_gat_pin_oe), .ch_gat_pin_o(ch_gat_pin_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [5:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        cfg_addr = AW'(a);
        #1;
        chk(req, $sformatf("rdata[%0d]", a), int'(cfg_rdata), exp);
    endtask

    task automatic zero_inputs();
        ch_clk_pin_i = '0; ch_gat_pin_i = '0; ch_out_i = '0; chip_xclk_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1: reset state
        for (int g = 0; g < NCH; g++) rd_chk("R1", g, 16);
        chk("R1", "clk_pin_oe", int'(ch_clk_pin_oe), 0);
        chk("R1", "gat_pin_oe", int'(ch_gat_pin_oe), 0);
        chk("R1", "clk_en", int'(ch_clk_en_o), 0);
        chk("R1", "gate", int'(ch_gate_o), 0);

        // R2: write, read back, unmapped addresses ignored
        for (int g = 0; g < NCH; g++) wr(g, 6'((g * 7 + 5) % 64));
        for (int a = NCH; a < (1 << AW); a++) wr(a, 6'h3f);
        @(negedge clk);
        for (int g = 0; g < NCH; g++) rd_chk("R2", g, (g * 7 + 5) % 64);
        for (int a = NCH; a < (1 << AW); a++) rd_chk("R2", a, 0);

        // R4 R5 R9: edge-following clock codes on every channel
        for (int g = 0; g < NCH; g++) begin
            for (int ci = 0; ci < 3; ci++) begin
                int c;
                string req;
                logic [NCH-1:0] pin_m, out_m;
                logic [NC-1:0]  x_m;
                c = (ci == 0) ? 0 : (ci == 1) ? 6 : 7;
                req = (ci == 0) ? "R4" : (ci == 1) ? "R5" : "R9";
                pin_m = '0; out_m = '0; x_m = '0;
                if (c == 0) pin_m[g] = 1'b1;
                if (c == 6) out_m[(g + NCH - 1) % NCH] = 1'b1;
                if (c == 7) x_m[g / 3] = 1'b1;
                wr(g, 6'(c));
                zero_inputs();
                @(negedge clk); @(negedge clk);
                ch_clk_pin_i = ~pin_m; ch_out_i = ~out_m; chip_xclk_i = ~x_m;
                #1;
                chk(req, $sformatf("ch%0d code%0d other sources rise", g, c), int'(ch_clk_en_o[g]), 0);
                @(negedge clk);
                ch_clk_pin_i = '1; ch_out_i = '1; chip_xclk_i = '1;
                #1;
                chk(req, $sformatf("ch%0d code%0d source rise", g, c), int'(ch_clk_en_o[g]), 1);
                chk("R8", $sformatf("ch%0d clk_pin_oe code%0d", g, c), int'(ch_clk_pin_oe[g]), (c != 0) ? 1 : 0);
                chk("R8", $sformatf("ch%0d clk_pin_o code%0d", g, c), int'(ch_clk_pin_o[g]), (c != 0) ? 1 : 0);
                @(negedge clk); #1;
                chk(req, $sformatf("ch%0d code%0d held high", g, c), int'(ch_clk_en_o[g]), 0);
            end
        end

        // R9: shared pin reaches exactly its own chip's three channels
        for (int g = 0; g < NCH; g++) wr(g, (g / 3 == 1) ? 6'd7 : 6'd0);
        zero_inputs();
        @(negedge clk); @(negedge clk);
        chip_xclk_i = 3'b101; #1;
        chk("R9", "other chips' shared pins", int'(ch_clk_en_o), 0);
        @(negedge clk);
        chip_xclk_i = 3'b111; #1;
        chk("R9", "own shared pin", int'(ch_clk_en_o), 9'b000_111_000);

        // R6 R7 R8: every gate code, four patterns per channel
        for (int g = 0; g < NCH; g++) begin
            for (int gc = 0; gc < 8; gc++) begin
                int so;
                so = (g + NCH - 2) % NCH;
                wr(g, 6'(gc * 8 + 1));
                for (int p = 0; p < 4; p++) begin
                    int exp;
                    string req;
                    @(negedge clk);
                    case (p)
                        0: begin ch_gat_pin_i = '0; ch_out_i = '0; end
                        1: begin ch_gat_pin_i = '1; ch_out_i = '1; end
                        2: begin ch_gat_pin_i = '1; ch_out_i = '1;
                                 ch_gat_pin_i[g] = 1'b0; ch_out_i[so] = 1'b0; end
                        default: begin ch_gat_pin_i = '0; ch_out_i = '0;
                                 ch_gat_pin_i[g] = 1'b1; ch_out_i[so] = 1'b1; end
                    endcase
                    #1;
                    case (gc)
                        0: exp = 1;
                        1: exp = 0;
                        2: exp = int'(ch_gat_pin_i[g]);
                        3: exp = ch_out_i[so] ? 0 : 1;
                        default: exp = 0;
                    endcase
                    req = (gc == 3) ? "R7" : "R6";
                    chk(req, $sformatf("ch%0d gate code%0d pat%0d", g, gc, p), int'(ch_gate_o[g]), exp);
                    chk("R8", $sformatf("ch%0d gat_pin_oe code%0d", g, gc), int'(ch_gat_pin_oe[g]), (gc != 2) ? 1 : 0);
                    chk("R8", $sformatf("ch%0d gat_pin_o code%0d", g, gc), int'(ch_gat_pin_o[g]), (gc != 2) ? exp : 0);
                end
            end
            chk("R3", $sformatf("ch%0d 10 MHz rate", g), int'(ch_clk_en_o[g]), 1);
            chk("R8", $sformatf("ch%0d clk_pin_o driven", g), int'(ch_clk_pin_o[g]), 1);
        end

        // R3: interval between internal rate pulses
        zero_inputs();
        for (int c = 1; c <= 5; c++) begin
            int exp, n, guard;
            exp = 1;
            for (int i = 1; i < c; i++) exp = exp * 10;
            wr(4, 6'(c));
            guard = 0;
            @(negedge clk); #1;
            while (!ch_clk_en_o[4] && guard < 30000) begin
                @(negedge clk); #1; guard++;
            end
            n = 0;
            do begin
                @(negedge clk); #1; n++;
            end while (!ch_clk_en_o[4] && n < 30000);
            chk("R3", $sformatf("pulse interval code%0d", c), n, exp);
        end

        // R1: reset in mid-run restores the select registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int g = 0; g < NCH; g++) rd_chk("R1", g, 16);
        chk("R1", "clk_pin_oe after reset", int'(ch_clk_pin_oe), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule